// File: doc/BRIEF.md
# Lock Loss Detector with Hysteresis

This block watches a phase-locked loop by timing the rising edges that reach its phase comparator. It receives one-cycle strobes for the divided reference edge and the divided feedback edge, both already synchronised to a fast sampling clock. It pairs each reference edge with its feedback partner and counts the gap between them in sampling-clock ticks. Each pairing produces a per-comparison error magnitude that other logic can use. A lock-loss flag is driven from these magnitudes with two thresholds: a large gap raises the flag, and only a small gap lowers it again.

An edge pairing engine has three states. `PAIR_IDLE` waits for either strobe. `PAIR_WAIT_FB` is entered when a reference edge arrives alone, and `PAIR_WAIT_REF` when a feedback edge arrives alone. A waiting state goes back to `PAIR_IDLE` on the partner strobe (transition *pair*) or when the wait reaches the timeout (transition *expire*). If both strobes arrive in the same tick in `PAIR_IDLE`, the result is immediate and the engine stays in `PAIR_IDLE` (transition *coincide*).

The flag machine also has three states. `FLAG_LOCKED` drives the flag low. `FLAG_HOLD` is entered from `FLAG_LOCKED` on an excessive gap or an expiry (transition *trip*); it keeps the flag high for a guaranteed minimum time and ignores results meanwhile. When its counter ends, `FLAG_HOLD` moves to `FLAG_LOST` (transition *settle*). `FLAG_LOST` keeps the flag high until a comparison falls under the clear threshold, and then returns to `FLAG_LOCKED` (transition *relock*). Reset enters `FLAG_LOST`.

Top module: `lock_loss_monitor`

## Requirements
- R1: A pairing whose second strobe is sampled k ticks after the first reports err_valid for one cycle, with err_mag = k and err_timeout = 0, in the cycle after that second strobe is sampled; this holds for either order and for every k up to and including the timeout limit. Coincident strobes report 0.
- R2: A reported magnitude strictly greater than SET_TICKS (default 4), seen while locked, raises lol in the cycle after err_valid. A magnitude equal to SET_TICKS does not raise it.
- R3: lol falls only after a result with err_timeout = 0 and err_mag strictly less than CLR_TICKS (default 2), seen in `FLAG_LOST`. A magnitude equal to CLR_TICKS does not lower it.
- R4: A result with CLR_TICKS <= err_mag <= SET_TICKS leaves lol unchanged, whether lol is high or low.
- R5: Every raising of lol from the locked state keeps lol high for at least MIN_PULSE ticks (default 10). Results that arrive in that window, including good ones, have no effect on lol.
- R6: If no partner arrives within period_ticks + SET_TICKS ticks of a lone strobe, a result is reported with err_timeout = 1 and err_mag = period_ticks + SET_TICKS, and lol is high in the following cycle.
- R7: After reset, lol = 1 and err_valid = 0. lol stays 1 until the first result below CLR_TICKS.
- R8: A repeated strobe of the same kind, sampled while the engine waits for a partner, is ignored. The pairing still measures from the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock; one tick is the unit of measurement |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_edge | input | 1 | One-tick strobe marking a divided reference rising edge |
| fb_edge | input | 1 | One-tick strobe marking a divided feedback rising edge |
| period_ticks | input | CNT_W | Comparison period in ticks; sets the pairing timeout |
| lol | output | 1 | Lock-loss flag, 1 = not locked |
| err_valid | output | 1 | One-tick pulse marking a new comparison result |
| err_mag | output | CNT_W+1 | Absolute edge gap in ticks for the current result |
| err_timeout | output | 1 | The current result came from an expired wait |

## Verification
Assertions check on every cycle how each result drives the flag. An over-threshold or expired result raises the flag, and an in-band result leaves it stable. The flag falls only right after a sub-clear result, and no raised flag falls before MIN_PULSE ticks. They also check that a partner strobe in a waiting state or coincident strobes in idle produce a valid, non-expired result. Only the bench scenarios can show the exact magnitudes for both edge orders, where the boundary values fall, the timeout length, that repeated strobes are ignored, and that a good result is dropped inside the hold window.

// File: rtl/lld_pkg.sv
package lld_pkg;

    typedef enum logic [1:0] {
        PAIR_IDLE     = 2'd0,
        PAIR_WAIT_FB  = 2'd1,
        PAIR_WAIT_REF = 2'd2
    } pair_state_t;

    typedef enum logic [1:0] {
        FLAG_LOCKED = 2'd0,
        FLAG_HOLD   = 2'd1,
        FLAG_LOST   = 2'd2
    } flag_state_t;

endpackage

// File: rtl/lld_edge_pair.sv
module lld_edge_pair
    import lld_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int SET_TICKS = 4,
    parameter int MAG_W     = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_edge,
    input  logic             fb_edge,
    input  logic [CNT_W-1:0] period_ticks,
    output logic             res_valid,
    output logic [MAG_W-1:0] res_mag,
    output logic             res_timeout
);

    localparam logic [MAG_W-1:0] SET_M = MAG_W'(SET_TICKS);
    localparam logic [MAG_W-1:0] ONE_M = MAG_W'(1);

    pair_state_t      state, state_nxt;
    logic [MAG_W-1:0] cnt, cnt_nxt;
    logic [MAG_W-1:0] limit;
    logic             hit, expire;
    logic [MAG_W-1:0] mag_now;

    assign limit = {1'b0, period_ticks} + SET_M;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        hit       = 1'b0;
        expire    = 1'b0;
        mag_now   = cnt;
        unique case (state)
            PAIR_IDLE: begin
                mag_now = '0;
                if (ref_edge && fb_edge) begin
                    hit = 1'b1;
                end else if (ref_edge) begin
                    state_nxt = PAIR_WAIT_FB;
                    cnt_nxt   = ONE_M;
                end else if (fb_edge) begin
                    state_nxt = PAIR_WAIT_REF;
                    cnt_nxt   = ONE_M;
                end
            end
            PAIR_WAIT_FB: begin
                if (fb_edge) begin
                    hit       = 1'b1;
                    state_nxt = PAIR_IDLE;
                end else if (cnt >= limit) begin
                    expire    = 1'b1;
                    state_nxt = PAIR_IDLE;
                end else begin
                    cnt_nxt = cnt + ONE_M;
                end
            end
            PAIR_WAIT_REF: begin
                if (ref_edge) begin
                    hit       = 1'b1;
                    state_nxt = PAIR_IDLE;
                end else if (cnt >= limit) begin
                    expire    = 1'b1;
                    state_nxt = PAIR_IDLE;
                end else begin
                    cnt_nxt = cnt + ONE_M;
                end
            end
            default: begin
                state_nxt = PAIR_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PAIR_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // result outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_mag     <= '0;
            res_timeout <= 1'b0;
        end else begin
            res_valid   <= hit | expire;
            res_timeout <= expire;
            if (hit | expire) begin
                res_mag <= mag_now;
            end
        end
    end

    // partner strobe closes a wait with a real pairing (R1)
    assert_partner_closes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == PAIR_WAIT_FB && fb_edge) || (state == PAIR_WAIT_REF && ref_edge))
        |=> (res_valid && !res_timeout));

    // coincident strobes in idle give zero gap (R1)
    assert_coincide_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PAIR_IDLE && ref_edge && fb_edge)
        |=> (res_valid && !res_timeout && res_mag == '0));

endmodule

// File: rtl/lld_lock_flag.sv
module lld_lock_flag
    import lld_pkg::*;
#(
    parameter int SET_TICKS = 4,
    parameter int CLR_TICKS = 2,
    parameter int MIN_PULSE = 10,
    parameter int MAG_W     = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [MAG_W-1:0] res_mag,
    input  logic             res_timeout,
    output logic             lol
);

    localparam int               HOLD_W = $clog2(MIN_PULSE + 1);
    localparam int               RUN_W  = HOLD_W + 1;
    localparam logic [MAG_W-1:0] SET_M  = MAG_W'(SET_TICKS);
    localparam logic [MAG_W-1:0] CLR_M  = MAG_W'(CLR_TICKS);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(MIN_PULSE - 1);
    localparam logic [RUN_W-1:0]  RUN_MAX   = {RUN_W{1'b1}};

    flag_state_t       state, state_nxt;
    logic [HOLD_W-1:0] hold_cnt, hold_cnt_nxt;
    logic              over, under, in_band;

    assign over    = res_valid && (res_timeout || (res_mag > SET_M));
    assign under   = res_valid && !res_timeout && (res_mag < CLR_M);
    assign in_band = res_valid && !res_timeout && (res_mag >= CLR_M) && (res_mag <= SET_M);

    always_comb begin
        state_nxt    = state;
        hold_cnt_nxt = hold_cnt;
        unique case (state)
            FLAG_LOCKED: begin
                if (over) begin
                    state_nxt    = FLAG_HOLD;
                    hold_cnt_nxt = '0;
                end
            end
            FLAG_HOLD: begin
                if (hold_cnt == HOLD_LAST) begin
                    state_nxt = FLAG_LOST;
                end else begin
                    hold_cnt_nxt = hold_cnt + HOLD_W'(1);
                end
            end
            FLAG_LOST: begin
                if (under) begin
                    state_nxt = FLAG_LOCKED;
                end
            end
            default: state_nxt = FLAG_LOST;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FLAG_LOST;
            hold_cnt <= '0;
        end else begin
            state    <= state_nxt;
            hold_cnt <= hold_cnt_nxt;
        end
    end

    // flag output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lol <= 1'b1;
        end else begin
            lol <= (state_nxt != FLAG_LOCKED);
        end
    end

    // checker state: length of the current high run of lol
    logic [RUN_W-1:0] run_len;
    logic             run_from_reset;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len        <= '0;
            run_from_reset <= 1'b1;
        end else if (!lol) begin
            run_len        <= '0;
            run_from_reset <= 1'b0;
        end else if (run_len != RUN_MAX) begin
            run_len <= run_len + RUN_W'(1);
        end
    end

    assert_trip_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (over && !lol) |=> lol);

    assert_clear_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lol) |-> $past(under));

    assert_band_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_band |=> $stable(lol));

    assert_min_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lol) && !run_from_reset) |-> (run_len >= RUN_W'(MIN_PULSE)));

    assert_expiry_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_timeout) |=> lol);

endmodule

// File: rtl/lock_loss_monitor.sv
module lock_loss_monitor #(
    parameter int CNT_W     = 8,
    parameter int SET_TICKS = 4,
    parameter int CLR_TICKS = 2,
    parameter int MIN_PULSE = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_edge,
    input  logic             fb_edge,
    input  logic [CNT_W-1:0] period_ticks,
    output logic             lol,
    output logic             err_valid,
    output logic [CNT_W:0]   err_mag,
    output logic             err_timeout
);

    localparam int MAG_W = CNT_W + 1;

    logic             res_valid;
    logic [MAG_W-1:0] res_mag;
    logic             res_timeout;

    lld_edge_pair #(
        .CNT_W     (CNT_W),
        .SET_TICKS (SET_TICKS),
        .MAG_W     (MAG_W)
    ) u_pair (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_edge     (ref_edge),
        .fb_edge      (fb_edge),
        .period_ticks (period_ticks),
        .res_valid    (res_valid),
        .res_mag      (res_mag),
        .res_timeout  (res_timeout)
    );

    lld_lock_flag #(
        .SET_TICKS (SET_TICKS),
        .CLR_TICKS (CLR_TICKS),
        .MIN_PULSE (MIN_PULSE),
        .MAG_W     (MAG_W)
    ) u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .res_valid   (res_valid),
        .res_mag     (res_mag),
        .res_timeout (res_timeout),
        .lol         (lol)
    );

    assign err_valid   = res_valid;
    assign err_mag     = res_mag;
    assign err_timeout = res_timeout;

    // reset state of the outputs (R7)
    assert_reset_state_R7: assert property (@(posedge clk)
        !rst_n |=> (lol && !err_valid));

endmodule

// File: tb/lock_loss_monitor_test.sv
module lock_loss_monitor_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int SET_T      = 4;
    localparam int CLR_T      = 2;
    localparam int MIN_P      = 10;
    localparam int PERIOD     = 20;
    localparam int LIMIT      = PERIOD + SET_T;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_edge = 1'b0;
    logic             fb_edge = 1'b0;
    logic [CNT_W-1:0] period_ticks = CNT_W'(PERIOD);
    logic             lol;
    logic             err_valid;
    logic [CNT_W:0]   err_mag;
    logic             err_timeout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct { int mag; bit tmo; string req; } exp_t;
    exp_t sb[$];

    lock_loss_monitor #(
        .CNT_W     (CNT_W),
        .SET_TICKS (SET_T),
        .CLR_TICKS (CLR_T),
        .MIN_PULSE (MIN_P)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_edge     (ref_edge),
        .fb_edge      (fb_edge),
        .period_ticks (period_ticks),
        .lol          (lol),
        .err_valid    (err_valid),
        .err_mag      (err_mag),
        .err_timeout  (err_timeout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input int mag, input bit tmo, input string req);
        exp_t e;
        e.mag = mag; e.tmo = tmo; e.req = req;
        sb.push_back(e);
    endtask

    // monitor: pops one expected result per err_valid pulse
    always @(negedge clk) begin
        if (rst_n && err_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1 unexpected result", int'(err_mag), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(int'(err_mag) == e.mag, {e.req, " magnitude"}, int'(err_mag), e.mag);
                check(err_timeout == e.tmo, {e.req, " timeout bit"}, int'(err_timeout), int'(e.tmo));
            end
        end
    end

    // pairing with gap k; first strobe is ref when ref_first
    task automatic send_pair(input int k, input bit ref_first, input bit exp_lol, input string req);
        push(k, 1'b0, req);
        @(negedge clk);
        if (k == 0) begin
            ref_edge = 1'b1; fb_edge = 1'b1;
            @(negedge clk);
            ref_edge = 1'b0; fb_edge = 1'b0;
        end else begin
            if (ref_first) ref_edge = 1'b1; else fb_edge = 1'b1;
            @(negedge clk);
            ref_edge = 1'b0; fb_edge = 1'b0;
            if (k > 1) repeat (k - 1) @(negedge clk);
            if (ref_first) fb_edge = 1'b1; else ref_edge = 1'b1;
            @(negedge clk);
            ref_edge = 1'b0; fb_edge = 1'b0;
        end
        @(negedge clk);
        check(lol == exp_lol, {req, " lol"}, int'(lol), int'(exp_lol));
        repeat (2) @(negedge clk);
    endtask

    // lone strobe left to expire
    task automatic send_lone(input bit is_ref, input string req);
        push(LIMIT, 1'b1, req);
        @(negedge clk);
        if (is_ref) ref_edge = 1'b1; else fb_edge = 1'b1;
        @(negedge clk);
        ref_edge = 1'b0; fb_edge = 1'b0;
        repeat (LIMIT) @(negedge clk);
        @(negedge clk);
        check(lol == 1'b1, {req, " lol after expiry"}, int'(lol), 1);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7 reset state
        check(lol == 1'b1, "R7 lol in reset", int'(lol), 1);
        check(err_valid == 1'b0, "R7 err_valid in reset", int'(err_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(lol == 1'b1, "R7 lol after reset", int'(lol), 1);

        send_pair(3, 1'b1, 1'b1, "R4_R7 band gap keeps lol high");
        send_pair(2, 1'b1, 1'b1, "R3 gap equal to clear threshold");
        send_pair(1, 1'b0, 1'b0, "R3_R7 feedback-first gap 1 clears");
        send_pair(4, 1'b1, 1'b0, "R2 gap equal to set threshold");
        send_pair(3, 1'b0, 1'b0, "R4 band gap keeps lol low");
        send_pair(2, 1'b1, 1'b0, "R4 lower band edge keeps lol low");
        send_pair(6, 1'b0, 1'b1, "R2 feedback-first gap 6 sets");

        // R5: good result inside the hold window is dropped
        send_pair(0, 1'b1, 1'b1, "R5 good result inside hold");
        repeat (15) @(negedge clk);
        check(lol == 1'b1, "R5 lol still high after hold", int'(lol), 1);
        send_pair(0, 1'b1, 1'b0, "R1_R3 coincident strobes clear");

        // R8: repeated reference strobe ignored
        push(3, 1'b0, "R8 repeated strobe");
        @(negedge clk); ref_edge = 1'b1;
        @(negedge clk); ref_edge = 1'b0;
        @(negedge clk); ref_edge = 1'b1;
        @(negedge clk); ref_edge = 1'b0; fb_edge = 1'b1;
        @(negedge clk); fb_edge = 1'b0;
        @(negedge clk);
        check(lol == 1'b0, "R8 lol unchanged", int'(lol), 0);
        repeat (2) @(negedge clk);

        send_lone(1'b1, "R6 reference without partner");
        repeat (12) @(negedge clk);
        send_pair(1, 1'b1, 1'b0, "R3 relock after expiry");
        send_lone(1'b0, "R6 feedback without partner");
        repeat (12) @(negedge clk);
        send_pair(LIMIT, 1'b1, 1'b1, "R1_R6 gap at timeout limit pairs");
        repeat (12) @(negedge clk);
        send_pair(0, 1'b0, 1'b0, "R3 relock");
        send_pair(LIMIT, 1'b0, 1'b1, "R1_R2 feedback-first gap at limit");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R1 all results seen", sb.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule